// File: doc/BRIEF.md
# Programming-Mode Address Counter

This block keeps the word pointer that a flash microcontroller uses while it is held in serial programming mode. It also turns that logical pointer into the physical location that the program and configuration arrays see. Entering programming mode clears the pointer. An increment strobe steps it forward, and a load-configuration strobe jumps it to the base of configuration space. Once the pointer reaches configuration space it cannot leave that space. Only a fresh mode entry, which is the reset, brings it back to user space.

A single parameter sets how many user words are implemented: 1024 or 2048. User addresses alias modulo that size. Configuration space has its own 32-word physical row at logical 0x2000-0x201F. Higher logical addresses inside configuration space fold back onto user memory.

Three qualification outputs tell the write sequencer which kind of storage a program operation would touch: user words, the identification words, or the configuration word. All outputs are decoded combinationally from the registered pointer, so they are valid in the cycle after a strobe.

Top module: `pm_addr_ctr`

## Requirements
- R1: While `rst_n` is low, the pointer is 0x0000 and `cfg_space_o` is 0.
- R2: Each clock cycle with `incr_i`=1 and `load_cfg_i`=0 adds one to the pointer. With both strobes low, the pointer holds its value.
- R3: A cycle with `load_cfg_i`=1 sets the pointer to 0x2000, even when `incr_i` is also 1.
- R4: Incrementing from 0x1FFF gives 0x2000.
- R5: Once bit 13 is set it stays set. Incrementing from 0x3FFF gives 0x2000. `cfg_space_o` equals bit 13 of the pointer.
- R6: For pointers below 0x2000, `phys_addr_o` is the pointer modulo USER_WORDS. With 2048 words, 0x0800 maps to 0x000.
- R7: For pointers 0x2000-0x201F, `cfg_row_o`=1 and `phys_addr_o` is the pointer minus 0x2000.
- R8: For pointers 0x2020-0x3FFF, `cfg_row_o`=0 and `phys_addr_o` is the pointer modulo USER_WORDS.
- R9: `wr_id_o`=1 exactly when the pointer is 0x2000-0x2003.
- R10: `wr_cfgword_o`=1 exactly when the pointer equals 0x2007.
- R11: `wr_user_o`=1 exactly when `cfg_row_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, programming-mode entry |
| incr_i | input | 1 | Increment strobe, one step per cycle high |
| load_cfg_i | input | 1 | Jump to configuration base 0x2000 |
| pc_o | output | 14 | Logical pointer |
| cfg_space_o | output | 1 | Pointer is in configuration space |
| cfg_row_o | output | 1 | Physical target is the configuration row |
| phys_addr_o | output | $clog2(USER_WORDS) | Physical word address within the selected array |
| wr_user_o | output | 1 | A program operation would touch user memory |
| wr_id_o | output | 1 | A program operation would touch an identification word |
| wr_cfgword_o | output | 1 | A program operation would touch the configuration word |

## Verification
The assertions assume the strobes are clean synchronous levels sampled at the rising edge. They also assume that a strobe held high for several cycles means that many separate commands.

The stimulus changes the strobes only on falling edges. It keeps them high for exactly the number of steps in each table row, then drops both before outputs are sampled on the next falling edge.

Long runs of increments carry the pointer through both wrap points: user-to-configuration and top-of-configuration. This lets the sticky behaviour be seen directly.

// File: rtl/pm_addr_ctr.sv
module pm_addr_ctr #(
  parameter int USER_WORDS = 2048
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          incr_i,
  input  logic                          load_cfg_i,
  output logic [13:0]                   pc_o,
  output logic                          cfg_space_o,
  output logic                          cfg_row_o,
  output logic [$clog2(USER_WORDS)-1:0] phys_addr_o,
  output logic                          wr_user_o,
  output logic                          wr_id_o,
  output logic                          wr_cfgword_o
);
  localparam int UA_W  = $clog2(USER_WORDS);
  localparam int ROW_W = 5;

  logic [13:0] pc_q;
  logic [13:0] sum;

  assign sum = pc_q + 14'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc_q <= 14'h0000;
    else if (load_cfg_i) pc_q <= 14'h2000;
    else if (incr_i)     pc_q <= {pc_q[13] | sum[13], sum[12:0]};
  end

  assign pc_o         = pc_q;
  assign cfg_space_o  = pc_q[13];
  assign cfg_row_o    = pc_q[13] && (pc_q[12:ROW_W] == '0);
  assign phys_addr_o  = cfg_row_o ? {{(UA_W-ROW_W){1'b0}}, pc_q[ROW_W-1:0]}
                                  : pc_q[UA_W-1:0];
  assign wr_user_o    = !cfg_row_o;
  assign wr_id_o      = cfg_row_o && (pc_q[4:2] == 3'b000);
  assign wr_cfgword_o = cfg_row_o && (pc_q[4:0] == 5'h07);
endmodule

// File: rtl/pm_addr_ctr_chk.sv
module pm_addr_ctr_chk #(
  parameter int USER_WORDS = 2048
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          incr_i,
  input logic                          load_cfg_i,
  input logic [13:0]                   pc_o,
  input logic                          cfg_space_o,
  input logic                          cfg_row_o,
  input logic [$clog2(USER_WORDS)-1:0] phys_addr_o,
  input logic                          wr_user_o,
  input logic                          wr_id_o,
  input logic                          wr_cfgword_o
);
  AST_LOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    load_cfg_i |=> pc_o == 14'h2000); // R3
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (incr_i && !load_cfg_i && pc_o != 14'h3FFF) |=> pc_o == $past(pc_o) + 14'd1); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!incr_i && !load_cfg_i) |=> $stable(pc_o)); // R2
  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_space_o |=> cfg_space_o); // R5
  AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (incr_i && pc_o == 14'h3FFF) |=> pc_o == 14'h2000); // R5
  AST_CFGWORD_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfgword_o |-> (cfg_row_o && phys_addr_o == 7 && !wr_user_o)); // R10
  AST_ID_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_id_o |-> (cfg_space_o && phys_addr_o < 4)); // R9
endmodule

bind pm_addr_ctr pm_addr_ctr_chk #(.USER_WORDS(USER_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .incr_i(incr_i), .load_cfg_i(load_cfg_i),
  .pc_o(pc_o), .cfg_space_o(cfg_space_o), .cfg_row_o(cfg_row_o),
  .phys_addr_o(phys_addr_o), .wr_user_o(wr_user_o), .wr_id_o(wr_id_o),
  .wr_cfgword_o(wr_cfgword_o)
);

// File: tb/pm_addr_ctr_tb.sv
module pm_addr_ctr_tb;
  localparam int USER_WORDS = 2048;
  localparam int PA_W = $clog2(USER_WORDS);
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic incr_i = 1'b0;
  logic load_cfg_i = 1'b0;
  logic [13:0] pc_o;
  logic cfg_space_o, cfg_row_o, wr_user_o, wr_id_o, wr_cfgword_o;
  logic [PA_W-1:0] phys_addr_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pm_addr_ctr #(.USER_WORDS(USER_WORDS)) u_dut (
    .clk(clk), .rst_n(rst_n), .incr_i(incr_i), .load_cfg_i(load_cfg_i),
    .pc_o(pc_o), .cfg_space_o(cfg_space_o), .cfg_row_o(cfg_row_o),
    .phys_addr_o(phys_addr_o), .wr_user_o(wr_user_o), .wr_id_o(wr_id_o),
    .wr_cfgword_o(wr_cfgword_o)
  );

  // {req[3:0], op[1:0] (01 incr, 10 load, 11 both), steps[15:0], pc[13:0], phys[10:0],
  //  flags[4:0] = {cfg_space, cfg_row, wr_user, wr_id, wr_cfgword}}
  localparam logic [51:0] VEC [NV] = '{
    {4'd2,  2'b01, 16'd1,     14'h0001, 11'h001, 5'b00100},  // R2
    {4'd2,  2'b01, 16'h07FE,  14'h07FF, 11'h7FF, 5'b00100},  // R2
    {4'd6,  2'b01, 16'd1,     14'h0800, 11'h000, 5'b00100},  // R6 alias
    {4'd6,  2'b01, 16'h17FF,  14'h1FFF, 11'h7FF, 5'b00100},  // R6
    {4'd4,  2'b01, 16'd1,     14'h2000, 11'h000, 5'b11010},  // R4
    {4'd9,  2'b01, 16'd3,     14'h2003, 11'h003, 5'b11010},  // R9 last ID word
    {4'd9,  2'b01, 16'd1,     14'h2004, 11'h004, 5'b11000},  // R9
    {4'd7,  2'b01, 16'd2,     14'h2006, 11'h006, 5'b11000},  // R7
    {4'd10, 2'b01, 16'd1,     14'h2007, 11'h007, 5'b11001},  // R10
    {4'd10, 2'b01, 16'd1,     14'h2008, 11'h008, 5'b11000},  // R10
    {4'd7,  2'b01, 16'h0017,  14'h201F, 11'h01F, 5'b11000},  // R7 row top
    {4'd8,  2'b01, 16'd1,     14'h2020, 11'h020, 5'b10100},  // R8 R11 fold
    {4'd8,  2'b01, 16'h07E0,  14'h2800, 11'h000, 5'b10100},  // R8
    {4'd5,  2'b01, 16'h17FF,  14'h3FFF, 11'h7FF, 5'b10100},  // R5
    {4'd5,  2'b01, 16'd1,     14'h2000, 11'h000, 5'b11010},  // R5 top wrap
    {4'd11, 2'b01, 16'd5,     14'h2005, 11'h005, 5'b11000},  // R11
    {4'd3,  2'b11, 16'd1,     14'h2000, 11'h000, 5'b11010}   // R3 both strobes
  };

  task automatic check(input int req, input logic [13:0] epc,
                       input logic [PA_W-1:0] eph, input logic [4:0] efl);
    logic [4:0] fl;
    fl = {cfg_space_o, cfg_row_o, wr_user_o, wr_id_o, wr_cfgword_o};
    checks++;
    if (pc_o !== epc || phys_addr_o !== eph || fl !== efl) begin
      fails++;
      $display("FAIL R%0d: pc=%h phys=%h flags=%b expected pc=%h phys=%h flags=%b",
               req, pc_o, phys_addr_o, fl, epc, eph, efl);
    end
  endtask

  task automatic step(input logic [1:0] op, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      incr_i = op[0];
      load_cfg_i = op[1];
    end
    @(negedge clk);
    incr_i = 1'b0;
    load_cfg_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, 14'h0000, '0, 5'b00100);               // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(2, 14'h0000, '0, 5'b00100);               // R2 idle holds
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][47:46], int'(VEC[v][45:30]));
      check(int'(VEC[v][51:48]), VEC[v][29:16], VEC[v][15:5], VEC[v][4:0]);
    end
    step(2'b10, 2);
    check(3, 14'h2000, '0, 5'b11010);               // R3 load within config
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check(1, 14'h0000, '0, 5'b00100);               // R1 R5 only reset leaves config
    rst_n = 1'b1;
    step(2'b01, 5);
    check(2, 14'h0005, 11'h005, 5'b00100);          // R2
    step(2'b11, 1);
    check(3, 14'h2000, '0, 5'b11010);               // R3 load wins from user space
    step(2'b00, 3);
    check(2, 14'h2000, '0, 5'b11010);               // R2 hold
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule